// File: doc/BRIEF.md
# Parity-Protected Address Translation Buffer

This block is a sixteen-entry, fully associative address translation buffer. Software fills an entry by supplying two 32-bit words in one write. The upper word carries the virtual page tag, a page-size code and a valid flag. The lower word carries the physical page number and ten access-attribute bits. A single even parity bit is generated for the whole entry on every write and is kept alongside the entry's fields. The entry therefore grows by that one bit only.

A translation request compares a virtual address against every entry in the same cycle. It returns a hit together with the physical address, or a miss-exception strobe. A parity fault in the selected entry is never allowed to produce a translation. It is reported as an ordinary miss, so the software miss handler simply reloads the entry. Entries can also be read back by index. A parity fault seen during a readback is flagged with the returned words, and the entry is invalidated at the same clock edge. A test-only input toggles any single stored bit so that the protection can be exercised.

Top module: `ptlb_top`

## Requirements
- R1: After reset every entry is all zero, so every entry is invalid and holds correct parity. With no request, `lk_hit` and `lk_miss` are low and `rd_valid` and `rd_perr` are low.
- R2: A write (`wr_en`) stores tag = `wr_hi[31:10]`, size code = `wr_hi[9:7]`, valid = `wr_hi[6]`, physical page = `wr_lo[31:10]` and attributes = `wr_lo[9:0]` into entry `wr_idx`. `wr_hi[5:0]` is ignored. Lookups see the new contents from the next cycle on.
- R3: The page size is 2^(10+2*size code) bytes. A valid entry matches when `lk_vaddr` and the entry tag agree at every bit position at or above log2(page size). On a hit, `lk_paddr` takes the physical page bits above that position and the `lk_vaddr` bits below it. The result is combinational, in the same cycle as `lk_req`.
- R4: `lk_miss` is high in every cycle where `lk_req` is high and no correct translation is returned, and `lk_hit` is then low. Both outputs are low whenever `lk_req` is low.
- R5: When several valid entries match, the entry with the lowest index is selected.
- R6: The stored parity bit makes the XOR over the whole 59-bit entry zero. A write always stores fresh parity, so rewriting a corrupted entry restores correct translation.
- R7: If the selected matching entry has a parity fault, the lookup gives `lk_miss` and not `lk_hit`, even when a higher-index entry also matches.
- R8: A read (`rd_en`, `rd_idx`) returns the entry one clock later on `rd_valid`, `rd_hi` and `rd_lo`. `rd_hi` uses the R2 layout with bits [5:0] zero, and `rd_perr` flags a parity fault. A read and a write to the same index in the same cycle return the old contents.
- R9: A read that finds a parity fault clears that entry's valid flag at the same clock edge, unless a write to that index takes place in that cycle. From the next cycle the entry no longer matches lookups.
- R10: `tst_flip_en` toggles bit `tst_flip_pos` of entry `tst_flip_idx`. Within the stored entry, bit 58 is parity, bits 57:36 the tag, 35:33 the size code, 32 the valid flag, 31:10 the physical page and 9:0 the attributes. Positions 59 and above change nothing, and a write to the same index in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | 4 | Entry written |
| wr_hi | input | 32 | Upper entry word: tag, size code, valid |
| wr_lo | input | 32 | Lower entry word: physical page, attributes |
| rd_en | input | 1 | Entry readback strobe |
| rd_idx | input | 4 | Entry read back |
| rd_valid | output | 1 | Readback data present (one cycle after `rd_en`) |
| rd_hi | output | 32 | Upper word read back |
| rd_lo | output | 32 | Lower word read back |
| rd_perr | output | 1 | Parity fault found in the entry read back |
| lk_req | input | 1 | Translation request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Correct translation found |
| lk_paddr | output | 32 | Translated physical address (meaningful with `lk_hit`) |
| lk_miss | output | 1 | Miss-exception strobe, including parity faults |
| tst_flip_en | input | 1 | Test: toggle one stored bit |
| tst_flip_idx | input | 4 | Test: entry to corrupt |
| tst_flip_pos | input | 6 | Test: bit position within the entry |

## Verification
Translation results are due in the same cycle as the request. The bench drives each request just after a falling edge and compares `lk_hit`, `lk_miss` and `lk_paddr` one time unit later, before the next rising edge. Readback words and the parity flag are due one rising edge after `rd_en`, so they are compared at the following falling edge. Writes, bit flips and readback invalidations all take effect at that same edge. The reference model applies them in the order invalidate, flip, write, so the next cycle's lookup is predicted against the updated contents.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int ADDR_W    = 32;
  localparam int MIN_PG_LG = 10;
  localparam int SIZE_W    = 3;
  localparam int ATTR_W    = 10;
  localparam int TAG_W     = ADDR_W - MIN_PG_LG;
  localparam int RPN_W     = ADDR_W - MIN_PG_LG;
  localparam int HI_PAD    = ADDR_W - TAG_W - SIZE_W - 1;

  typedef struct packed {
    logic              par;
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic              valid;
    logic [RPN_W-1:0]  rpn;
    logic [ATTR_W-1:0] attr;
  } ent_t;

  localparam int ENT_BITS = $bits(ent_t);
  localparam int POS_W    = $clog2(ENT_BITS);

  // Even parity over every field except the parity bit itself.
  function automatic logic gen_par(ent_t e);
    return ^{e.tag, e.size, e.valid, e.rpn, e.attr};
  endfunction

  // True when the whole stored entry, parity included, is consistent.
  function automatic logic ent_clean(ent_t e);
    return ~(^e);
  endfunction

  // Ones at and above the page offset for a given size code.
  function automatic logic [ADDR_W-1:0] page_hi_mask(logic [SIZE_W-1:0] sz);
    return {ADDR_W{1'b1}} << (MIN_PG_LG + 2 * int'(sz));
  endfunction
endpackage

// File: rtl/ptlb_store.sv
module ptlb_store
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  ent_t                     wr_ent_i,
  input  logic                     inv_en_i,
  input  logic [IDX_W-1:0]         inv_idx_i,
  input  logic                     flip_en_i,
  input  logic [IDX_W-1:0]         flip_idx_i,
  input  logic [POS_W-1:0]         flip_pos_i,
  output ent_t [ENTRIES-1:0]       ents_o
);

  logic [ENT_BITS-1:0] flip_mask;
  logic                flip_in_range;

  assign flip_mask     = {{(ENT_BITS-1){1'b0}}, 1'b1} << flip_pos_i;
  assign flip_in_range = int'(flip_pos_i) < ENT_BITS;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    ent_t ent_q, ent_d;
    logic ent_en;

    always_comb begin
      ent_d  = ent_q;
      ent_en = 1'b0;
      if (inv_en_i && inv_idx_i == IDX_W'(g)) begin
        ent_d.valid = 1'b0;
        ent_en      = 1'b1;
      end
      if (flip_en_i && flip_in_range && flip_idx_i == IDX_W'(g)) begin
        ent_d  = ent_t'(ent_d ^ flip_mask);
        ent_en = 1'b1;
      end
      if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        ent_d     = wr_ent_i;
        ent_d.par = gen_par(wr_ent_i);
        ent_en    = 1'b1;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ent_q <= '0;
      else if (ent_en) ent_q <= ent_d;
    end

    assign ents_o[g] = ent_q;
  end

  // R6: a freshly written entry is always parity-consistent
  p_wr_fresh_par_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ent_clean(ents_o[$past(wr_idx_i)]));

  // R9: readback invalidation clears the valid flag unless a write overrides it
  p_inv_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_en_i && !(wr_en_i && wr_idx_i == inv_idx_i))
    |=> !ents_o[$past(inv_idx_i)].valid);

  // R10: an in-range flip with no competing update changes the entry
  p_flip_toggles_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flip_en_i && flip_in_range && !(wr_en_i && wr_idx_i == flip_idx_i)
     && !(inv_en_i && inv_idx_i == flip_idx_i))
    |=> ents_o[$past(flip_idx_i)] != $past(ents_o[flip_idx_i]));

endmodule

// File: rtl/ptlb_lookup.sv
module ptlb_lookup
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  ent_t [ENTRIES-1:0]   ents_i,
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    vaddr_i,
  output logic                 hit_o,
  output logic                 miss_o,
  output logic [ADDR_W-1:0]    paddr_o
);

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   sel;
  ent_t               sel_ent;
  logic [ADDR_W-1:0]  sel_mask;
  logic               found;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] tag_addr;
    assign tag_addr = {ents_i[g].tag, {MIN_PG_LG{1'b0}}};
    assign match[g] = ents_i[g].valid &&
                      (((vaddr_i ^ tag_addr) & page_hi_mask(ents_i[g].size)) == '0);
  end

  // Lowest index wins among simultaneous matches.
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign found    = |match;
  assign sel_ent  = ents_i[sel];
  assign sel_mask = page_hi_mask(sel_ent.size);

  assign hit_o   = req_i && found && ent_clean(sel_ent);
  assign miss_o  = req_i && !hit_o;
  assign paddr_o = ({sel_ent.rpn, {MIN_PG_LG{1'b0}}} & sel_mask) | (vaddr_i & ~sel_mask);

endmodule

// File: rtl/ptlb_readback.sv
module ptlb_readback
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_en_i,
  input  logic [IDX_W-1:0]     rd_idx_i,
  input  ent_t [ENTRIES-1:0]   ents_i,
  output logic                 inv_en_o,
  output logic [IDX_W-1:0]     inv_idx_o,
  output logic                 rd_valid_o,
  output logic [ADDR_W-1:0]    rd_hi_o,
  output logic [ADDR_W-1:0]    rd_lo_o,
  output logic                 rd_perr_o
);

  ent_t              cur;
  logic              cur_bad;
  logic              valid_d, perr_d;
  logic [ADDR_W-1:0] hi_d, lo_d;

  assign cur     = ents_i[rd_idx_i];
  assign cur_bad = !ent_clean(cur);

  assign inv_en_o  = rd_en_i && cur_bad;
  assign inv_idx_o = rd_idx_i;

  always_comb begin
    valid_d = rd_en_i;
    perr_d  = rd_en_i && cur_bad;
    hi_d    = {cur.tag, cur.size, cur.valid, {HI_PAD{1'b0}}};
    lo_d    = {cur.rpn, cur.attr};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_perr_o  <= 1'b0;
    end else begin
      rd_valid_o <= valid_d;
      rd_perr_o  <= perr_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hi_o <= '0;
      rd_lo_o <= '0;
    end else if (rd_en_i) begin
      rd_hi_o <= hi_d;
      rd_lo_o <= lo_d;
    end
  end

  // R8: every read request is answered on the next cycle
  p_rd_answer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  // R8: the parity flag only accompanies returned data
  p_perr_with_data_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_perr_o |-> rd_valid_o);

endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter  int ENTRIES = 16,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [31:0]        wr_hi,
  input  logic [31:0]        wr_lo,
  input  logic               rd_en,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic               rd_valid,
  output logic [31:0]        rd_hi,
  output logic [31:0]        rd_lo,
  output logic               rd_perr,
  input  logic               lk_req,
  input  logic [31:0]        lk_vaddr,
  output logic               lk_hit,
  output logic [31:0]        lk_paddr,
  output logic               lk_miss,
  input  logic               tst_flip_en,
  input  logic [IDX_W-1:0]   tst_flip_idx,
  input  logic [5:0]         tst_flip_pos
);

  ent_t [ENTRIES-1:0] ents;
  ent_t               wr_ent;
  logic               inv_en;
  logic [IDX_W-1:0]   inv_idx;
  logic               unused_hi_pad;

  always_comb begin
    wr_ent       = '0;
    wr_ent.tag   = wr_hi[ADDR_W-1 -: TAG_W];
    wr_ent.size  = wr_hi[HI_PAD+1 +: SIZE_W];
    wr_ent.valid = wr_hi[HI_PAD];
    wr_ent.rpn   = wr_lo[ADDR_W-1 -: RPN_W];
    wr_ent.attr  = wr_lo[ATTR_W-1:0];
  end
  assign unused_hi_pad = ^wr_hi[HI_PAD-1:0];

  ptlb_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_ent_i   (wr_ent),
    .inv_en_i   (inv_en),
    .inv_idx_i  (inv_idx),
    .flip_en_i  (tst_flip_en),
    .flip_idx_i (tst_flip_idx),
    .flip_pos_i (POS_W'(tst_flip_pos)),
    .ents_o     (ents)
  );

  ptlb_lookup #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lookup (
    .ents_i  (ents),
    .req_i   (lk_req),
    .vaddr_i (lk_vaddr),
    .hit_o   (lk_hit),
    .miss_o  (lk_miss),
    .paddr_o (lk_paddr)
  );

  ptlb_readback #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_readback (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rd_en_i    (rd_en),
    .rd_idx_i   (rd_idx),
    .ents_i     (ents),
    .inv_en_o   (inv_en),
    .inv_idx_o  (inv_idx),
    .rd_valid_o (rd_valid),
    .rd_hi_o    (rd_hi),
    .rd_lo_o    (rd_lo),
    .rd_perr_o  (rd_perr)
  );

  // R4: no translation result is produced without a request
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> (!lk_hit && !lk_miss));

  // R9: an entry invalidated by readback cannot translate a request for its own tag
  p_no_hit_after_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(wr_en && wr_idx == inv_idx))
    |=> !ents[$past(inv_idx)].valid);

endmodule

// File: tb/ptlb_top_tb.sv
module ptlb_top_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, lk_req, tst_flip_en;
  logic [3:0]  wr_idx, rd_idx, tst_flip_idx;
  logic [5:0]  tst_flip_pos;
  logic [31:0] wr_hi, wr_lo, lk_vaddr;
  logic        rd_valid, rd_perr, lk_hit, lk_miss;
  logic [31:0] rd_hi, rd_lo, lk_paddr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference entry image: [58] parity, [57:36] tag, [35:33] size, [32] valid,
  // [31:10] physical page, [9:0] attributes.
  logic [58:0] mdl [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ptlb_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_lo(wr_lo),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_hi(rd_hi),
    .rd_lo(rd_lo), .rd_perr(rd_perr),
    .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
    .lk_paddr(lk_paddr), .lk_miss(lk_miss),
    .tst_flip_en(tst_flip_en), .tst_flip_idx(tst_flip_idx),
    .tst_flip_pos(tst_flip_pos)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic ref_lookup(input logic [31:0] va, output logic h, output logic [31:0] pa);
    int sel = -1;
    int sel_sh = 10;
    h  = 1'b0;
    pa = '0;
    for (int i = 15; i >= 0; i--) begin
      int sh = 10 + 2 * int'(mdl[i][35:33]);
      if (mdl[i][32] && ((va >> sh) == ({mdl[i][57:36], 10'b0} >> sh))) begin
        sel = i;
        sel_sh = sh;
      end
    end
    if (sel >= 0 && (^mdl[sel]) == 1'b0) begin
      logic [31:0] low;
      low = (32'h1 << sel_sh) - 32'h1;
      h   = 1'b1;
      pa  = ({mdl[sel][31:10], 10'b0} & ~low) | (va & low);
    end
  endtask

  // One clock: compare the combinational lookup, advance the model, then
  // compare the registered readback at the following falling edge.
  task automatic step(string tag);
    logic        eh;
    logic [31:0] epa, ehi, elo;
    logic        ev, eperr;
    #1;
    ref_lookup(lk_vaddr, eh, epa);
    chk(tag, "lk_hit", 32'(lk_hit), 32'(lk_req & eh));
    chk(tag, "lk_miss", 32'(lk_miss), 32'(lk_req & ~eh));
    if (lk_req && eh) chk(tag, "lk_paddr", lk_paddr, epa);
    ev = rd_en; eperr = 1'b0; ehi = '0; elo = '0;
    if (rd_en) begin
      ehi   = {mdl[rd_idx][57:36], mdl[rd_idx][35:33], mdl[rd_idx][32], 6'b0};
      elo   = mdl[rd_idx][31:0];
      eperr = ^mdl[rd_idx];
      if (eperr) mdl[rd_idx][32] = 1'b0;
    end
    if (tst_flip_en && tst_flip_pos < 6'd59)
      mdl[tst_flip_idx][tst_flip_pos] = ~mdl[tst_flip_idx][tst_flip_pos];
    if (wr_en) begin
      logic [57:0] body;
      body = {wr_hi[31:10], wr_hi[9:7], wr_hi[6], wr_lo};
      mdl[wr_idx] = {^body, body};
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "rd_valid", 32'(rd_valid), 32'(ev));
    chk(tag, "rd_perr", 32'(rd_perr), 32'(eperr));
    if (ev) begin
      chk(tag, "rd_hi", rd_hi, ehi);
      chk(tag, "rd_lo", rd_lo, elo);
    end
  endtask

  task automatic quiet();
    wr_en = 0; rd_en = 0; lk_req = 0; tst_flip_en = 0;
  endtask

  function automatic logic [31:0] mk_hi(logic [31:0] va, logic [2:0] sz, logic v);
    return {va[31:10], sz, v, 6'h2A};
  endfunction

  task automatic wr(int idx, logic [31:0] hi, logic [31:0] lo, string tag);
    quiet(); wr_en = 1; wr_idx = 4'(idx); wr_hi = hi; wr_lo = lo;
    step(tag); quiet();
  endtask

  task automatic rd(int idx, string tag);
    quiet(); rd_en = 1; rd_idx = 4'(idx);
    step(tag); quiet();
  endtask

  task automatic look(logic [31:0] va, string tag);
    quiet(); lk_req = 1; lk_vaddr = va;
    step(tag); quiet();
  endtask

  task automatic flip(int idx, int pos, string tag);
    quiet(); tst_flip_en = 1; tst_flip_idx = 4'(idx); tst_flip_pos = 6'(pos);
    step(tag); quiet();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    quiet();
    wr_idx = 0; rd_idx = 0; tst_flip_idx = 0; tst_flip_pos = 0;
    wr_hi = 0; wr_lo = 0; lk_vaddr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    step("R1");
    look(32'h1234_5678, "R1");
    rd(7, "R1");

    // R2 / R3: fill entries, translation visible the next cycle
    wr(0, mk_hi(32'h0040_1000, 3'd1, 1'b1), 32'h8000_2155, "R2");
    look(32'h0040_1ABC, "R2");
    wr(1, mk_hi(32'h1000_0000, 3'd3, 1'b1), 32'h2345_00AA, "R2");
    wr(2, mk_hi(32'h0000_0400, 3'd0, 1'b1), 32'h0FF0_0C03, "R2");
    wr(3, mk_hi(32'h7000_0000, 3'd7, 1'b1), 32'h4A00_03FF, "R2");
    wr(4, mk_hi(32'h0040_0000, 3'd5, 1'b1), 32'h9000_0000, "R2");
    wr(5, mk_hi(32'h5000_0000, 3'd2, 1'b0), 32'h6000_0001, "R2");
    look(32'h1000_BEEF, "R3");
    look(32'h0000_07FF, "R3");
    look(32'h70FF_FFFF, "R3");
    look(32'h0048_1234, "R3");

    // R5: overlapping entries 0 and 4, lowest index wins
    look(32'h0040_1004, "R5");

    // R4: misses and idle
    look(32'h5000_0000, "R4");
    look(32'h0000_0800, "R4");
    quiet(); lk_vaddr = 32'h1000_BEEF; step("R4");

    // R8: readback, including simultaneous write and read
    rd(1, "R8");
    rd(5, "R8");
    quiet(); wr_en = 1; wr_idx = 2; wr_hi = mk_hi(32'h0000_0400, 3'd0, 1'b1);
    wr_lo = 32'h0FF0_1003; rd_en = 1; rd_idx = 2; step("R8"); quiet();
    look(32'h0000_0456, "R8");

    // R7: corrupt entry 0; overlapping entry 4 must not be used
    flip(0, 3, "R7");
    look(32'h0040_1004, "R7");

    // R9: readback detects fault, invalidates, entry 4 now translates
    rd(0, "R9");
    look(32'h0040_1004, "R9");
    rd(0, "R9");

    // R6: corrupt the parity bit itself, then repair by rewriting
    flip(3, 58, "R6");
    look(32'h7012_3456, "R6");
    wr(3, mk_hi(32'h7000_0000, 3'd7, 1'b1), 32'h4A00_03FF, "R6");
    look(32'h7012_3456, "R6");

    // R10: out-of-range flip, flip overridden by write, flip of the valid flag
    flip(1, 60, "R10");
    look(32'h1000_0010, "R10");
    quiet(); tst_flip_en = 1; tst_flip_idx = 1; tst_flip_pos = 6'd20;
    wr_en = 1; wr_idx = 1; wr_hi = mk_hi(32'h1000_0000, 3'd3, 1'b1);
    wr_lo = 32'h2345_00AA; step("R10"); quiet();
    look(32'h1000_0010, "R10");
    flip(2, 32, "R10");
    look(32'h0000_0456, "R10");
    rd(2, "R10");

    // Mixed random traffic against the reference model (R3 R7 R9 R10)
    for (int n = 0; n < 600; n++) begin
      int k;
      quiet();
      k = $urandom_range(0, 7);
      if ($urandom_range(0, 3) == 0) begin
        wr_en = 1; wr_idx = 4'($urandom_range(0, 15));
        wr_hi = mk_hi(32'(k) << 22, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        wr_lo = $urandom;
      end
      if ($urandom_range(0, 2) == 0) begin rd_en = 1; rd_idx = 4'($urandom_range(0, 15)); end
      if ($urandom_range(0, 9) == 0) begin
        tst_flip_en = 1; tst_flip_idx = 4'($urandom_range(0, 15));
        tst_flip_pos = 6'($urandom_range(0, 63));
      end
      lk_req = 1'($urandom_range(0, 1));
      lk_vaddr = (32'(k) << 22) | (32'($urandom) & 32'h003F_FFFF);
      step("RND R3");
    end
    quiet();
    step("R4");

    finished = 1;
    summary();
  end
endmodule